// File: doc/BRIEF.md
# Windowed Bidirectional Readout Address Generator

This block produces the addresses for reading a rectangular region out of a 640 by 480 pixel array. One output beat names one 4-pixel kernel. The beat carries the 8-pixel column group that holds the kernel, a phase bit that says which half of the group is meant, and the row. The window begins at a column group and a row, and its width is given in kernels. The window runs to the array edge vertically, and it is cut off at the array edge horizontally if the width would pass it. Each axis has its own reverse bit that turns the scan direction around.

A frame begins with a one-cycle pulse on `frame_start` while the block is idle. The start column, start row, width and both reverse bits are captured at that moment, so later changes on those inputs do not affect the running frame. Beats leave on a valid/ready stream. A beat is transferred on every cycle in which `out_valid` and `out_ready` are both high. While `out_ready` is low, the beat on offer stays unchanged and the scan does not advance. The consumer may hold `out_ready` low for any number of cycles. The marker `out_eol` flags the last beat of each row, and `out_eof` flags the last beat of the frame.

Top module: `roi_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `busy` are low until a frame is started.
- R2: A `frame_start` pulse seen on a clock edge while idle makes `out_valid` high one cycle later with the first beat of the window. A `frame_start` seen while busy is ignored. The configuration inputs are captured only when a frame is accepted.
- R3: With reverse X low, kernel index k (pixel 4k) runs upward from 2·s, where s is the start column group. It stops after the width count or at kernel 159, whichever comes first. `out_col` is k/2 and `out_phase` is k mod 2 (0 = left half of the group).
- R4: With reverse X high, the kernel index starts at 2·s+1, the right half of the start group. It runs downward for the width count or until kernel 0, whichever comes first.
- R5: With reverse Y low, rows run from the start row upward to row 479.
- R6: With reverse Y high, rows run from the start row downward to row 0.
- R7: `out_eol` is high only on the last kernel of each row. `out_eof` is high only on the last kernel of the last row, and it never occurs without `out_eol`.
- R8: While `out_valid` is high and `out_ready` is low, all outputs hold their values on the next cycle.
- R9: The cycle after the `out_eof` beat is transferred, `out_valid` and `busy` are low and a new frame may be started.
- R10: A start column group above 79 is treated as 79. A start row above 479 is treated as 479. A width of 0 is treated as 1. Widths above 160 are limited by the edge cut of R3 and R4.
- R11: Start column 0, start row 0, width 160 and both reverse bits low give a full-array readout of 160 kernels on each of 480 rows, 76,800 beats in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that begins a frame while idle |
| cfg_col_start | input | 8 | Start column group (0..79) |
| cfg_row_start | input | 9 | Start row (0..479) |
| cfg_width_kern | input | 8 | Window width in 4-pixel kernels (1..160) |
| cfg_rev_x | input | 1 | 1 = scan columns right to left |
| cfg_rev_y | input | 1 | 1 = scan rows bottom to top |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | A beat is on offer |
| out_col | output | 7 | Column group address |
| out_phase | output | 1 | Kernel half within the group |
| out_row | output | 9 | Row address |
| out_eol | output | 1 | Last kernel of the row |
| out_eof | output | 1 | Last kernel of the frame |
| busy | output | 1 | A frame is in progress |

## Verification
The bench goes after the edges of the window. A window whose width runs past kernel 159 must stop at column group 79 phase 1. A design that forgot the cut would emit group 80 or wrap to 0. A reverse scan must begin on phase 1 of the start group and stop at kernel 0. An off-by-one in the reverse anchor shows up as a missing or extra first beat, and a missing floor shows up as a wrap to kernel 255. Out-of-range start values and a zero width check the clamping, which would otherwise produce addresses beyond the array or an endless row. A throttled `out_ready`, together with a changed configuration and a stray `frame_start` in the middle of a frame, catches designs that advance without a handshake or that sample the configuration more than once.

// File: rtl/roi_pkg.sv
package roi_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/roi_window_calc.sv
// Turns raw window settings into first/last kernel and row bounds,
// applying clamping and edge clipping for both scan directions.
module roi_window_calc #(
  parameter int NKERN = 160,
  parameter int NROWS = 480,
  parameter int KPG   = 2,
  parameter int SW    = 8,
  parameter int RW    = 9,
  parameter int WW    = 8,
  parameter int KW    = 8
) (
  input  logic [SW-1:0] col_start,
  input  logic [RW-1:0] row_start,
  input  logic [WW-1:0] width,
  input  logic          rev_x,
  input  logic          rev_y,
  output logic [KW-1:0] first_kern,
  output logic [KW-1:0] last_kern,
  output logic [RW-1:0] first_row,
  output logic [RW-1:0] last_row
);
  localparam int NGRP = NKERN / KPG;

  int grp_i, wid_i, fk_i, lk_i, row_i;

  always_comb begin
    grp_i = int'(col_start);
    if (grp_i > NGRP - 1) grp_i = NGRP - 1;
    wid_i = int'(width);
    if (wid_i < 1) wid_i = 1;
    row_i = int'(row_start);
    if (row_i > NROWS - 1) row_i = NROWS - 1;

    if (rev_x) begin
      // anchor on the far kernel of the start group, walk down
      fk_i = grp_i * KPG + KPG - 1;
      lk_i = fk_i - (wid_i - 1);
      if (lk_i < 0) lk_i = 0;
    end else begin
      fk_i = grp_i * KPG;
      lk_i = fk_i + (wid_i - 1);
      if (lk_i > NKERN - 1) lk_i = NKERN - 1;
    end
  end

  assign first_kern = KW'(fk_i);
  assign last_kern  = KW'(lk_i);
  assign first_row  = RW'(row_i);
  assign last_row   = rev_y ? '0 : RW'(NROWS - 1);
endmodule

// File: rtl/roi_stepper.sv
// One scan axis: holds bounds and direction, steps by one, can rewind.
module roi_stepper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_first,
  input  logic [W-1:0] load_last,
  input  logic         load_down,
  input  logic         rewind,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         at_last
);
  logic [W-1:0] first_q, last_q;
  logic         down_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value   <= '0;
      first_q <= '0;
      last_q  <= '0;
      down_q  <= 1'b0;
    end else if (load) begin
      value   <= load_first;
      first_q <= load_first;
      last_q  <= load_last;
      down_q  <= load_down;
    end else if (rewind) begin
      value <= first_q;
    end else if (step) begin
      value <= down_q ? value - 1'b1 : value + 1'b1;
    end
  end

  assign at_last = (value == last_q);
endmodule

// File: rtl/roi_addr_gen.sv
module roi_addr_gen #(
  parameter int COLS      = 640,
  parameter int ROWS      = 480,
  parameter int GROUP_PIX = 8,
  parameter int KERN_PIX  = 4,
  parameter int XSTART_W  = 8,
  parameter int WIDTH_W   = 8,
  localparam int NGRP  = COLS / GROUP_PIX,
  localparam int NKERN = COLS / KERN_PIX,
  localparam int KPG   = GROUP_PIX / KERN_PIX,
  localparam int CW    = $clog2(NGRP),
  localparam int KW    = $clog2(NKERN),
  localparam int RW    = $clog2(ROWS),
  localparam int PW    = (KPG > 1) ? $clog2(KPG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [XSTART_W-1:0] cfg_col_start,
  input  logic [RW-1:0]       cfg_row_start,
  input  logic [WIDTH_W-1:0]  cfg_width_kern,
  input  logic                cfg_rev_x,
  input  logic                cfg_rev_y,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [CW-1:0]       out_col,
  output logic [PW-1:0]       out_phase,
  output logic [RW-1:0]       out_row,
  output logic                out_eol,
  output logic                out_eof,
  output logic                busy
);
  import roi_pkg::*;

  scan_state_e state_q;
  logic [KW-1:0] win_fk, win_lk, kern;
  logic [RW-1:0] win_fr, win_lr;
  logic x_last, y_last, accept, fire;

  roi_window_calc #(
    .NKERN(NKERN), .NROWS(ROWS), .KPG(KPG),
    .SW(XSTART_W), .RW(RW), .WW(WIDTH_W), .KW(KW)
  ) u_calc (
    .col_start (cfg_col_start),
    .row_start (cfg_row_start),
    .width     (cfg_width_kern),
    .rev_x     (cfg_rev_x),
    .rev_y     (cfg_rev_y),
    .first_kern(win_fk),
    .last_kern (win_lk),
    .first_row (win_fr),
    .last_row  (win_lr)
  );

  assign accept = frame_start && (state_q == SCAN_IDLE);
  assign fire   = out_valid && out_ready;

  roi_stepper #(.W(KW)) u_xstep (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_first(win_fk),
    .load_last (win_lk),
    .load_down (cfg_rev_x),
    .rewind    (fire && x_last && !y_last),
    .step      (fire && !x_last),
    .value     (kern),
    .at_last   (x_last)
  );

  roi_stepper #(.W(RW)) u_ystep (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_first(win_fr),
    .load_last (win_lr),
    .load_down (cfg_rev_y),
    .rewind    (1'b0),
    .step      (fire && x_last && !y_last),
    .value     (out_row),
    .at_last   (y_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
    end else begin
      case (state_q)
        SCAN_IDLE: if (accept) state_q <= SCAN_RUN;
        SCAN_RUN:  if (fire && x_last && y_last) state_q <= SCAN_IDLE;
        default:   state_q <= SCAN_IDLE;
      endcase
    end
  end

  assign out_valid = (state_q == SCAN_RUN);
  assign busy      = (state_q == SCAN_RUN);
  assign out_col   = CW'(kern / KW'(KPG));

  generate
    if (KPG > 1) begin : g_phase
      assign out_phase = PW'(kern % KW'(KPG));
    end else begin : g_nophase
      assign out_phase = '0;
    end
  endgenerate

  assign out_eol = out_valid && x_last;
  assign out_eof = out_valid && x_last && y_last;
endmodule

// File: rtl/roi_addr_gen_chk.sv
module roi_addr_gen_chk #(
  parameter int NGRP = 80,
  parameter int ROWS = 480,
  parameter int CW   = 7,
  parameter int PW   = 1,
  parameter int RW   = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          out_ready,
  input logic          out_valid,
  input logic [CW-1:0] out_col,
  input logic [PW-1:0] out_phase,
  input logic [RW-1:0] out_row,
  input logic          out_eol,
  input logic          out_eof,
  input logic          busy
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_col) && $stable(out_phase)
      && $stable(out_row) && $stable(out_eol) && $stable(out_eof));

  p_eof_has_eol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_eol);

  p_row_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_eol |=> $stable(out_row));

  p_in_array_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_col) < NGRP) && (int'(out_row) < ROWS));

  p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eof |=> !out_valid && !busy);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !busy |=> out_valid);
endmodule

bind roi_addr_gen roi_addr_gen_chk #(
  .NGRP(NGRP), .ROWS(ROWS), .CW(CW), .PW(PW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .out_ready(out_ready),
  .out_valid(out_valid), .out_col(out_col), .out_phase(out_phase),
  .out_row(out_row), .out_eol(out_eol), .out_eof(out_eof), .busy(busy)
);

// File: tb/roi_addr_gen_tb.sv
module roi_addr_gen_tb;
  localparam int GEO_GRP  = 80;
  localparam int GEO_KERN = 160;
  localparam int GEO_ROWS = 480;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [7:0] cfg_col_start = '0;
  logic [8:0] cfg_row_start = '0;
  logic [7:0] cfg_width_kern = 8'd160;
  logic cfg_rev_x = 1'b0, cfg_rev_y = 1'b0;
  logic out_ready = 1'b1;
  logic out_valid, out_eol, out_eof, busy;
  logic [6:0] out_col;
  logic [0:0] out_phase;
  logic [8:0] out_row;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  roi_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_col_start(cfg_col_start), .cfg_row_start(cfg_row_start),
    .cfg_width_kern(cfg_width_kern), .cfg_rev_x(cfg_rev_x), .cfg_rev_y(cfg_rev_y),
    .out_ready(out_ready), .out_valid(out_valid), .out_col(out_col),
    .out_phase(out_phase), .out_row(out_row), .out_eol(out_eol),
    .out_eof(out_eof), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // encode: row*4096 + kernel*16 + eol*2 + eof
  task automatic build(input int cx, input int ry, input int w, input bit rx, input bit rvy);
    int g, r, wd, fk, lk, lr;
    g  = (cx > GEO_GRP - 1) ? GEO_GRP - 1 : cx;
    r  = (ry > GEO_ROWS - 1) ? GEO_ROWS - 1 : ry;
    wd = (w < 1) ? 1 : w;
    if (rx) begin
      fk = 2 * g + 1;
      lk = fk - wd + 1;
      if (lk < 0) lk = 0;
    end else begin
      fk = 2 * g;
      lk = fk + wd - 1;
      if (lk > GEO_KERN - 1) lk = GEO_KERN - 1;
    end
    lr = rvy ? 0 : GEO_ROWS - 1;
    exp_q.delete();
    for (int row = r; ; row = rvy ? row - 1 : row + 1) begin
      for (int k = fk; ; k = rx ? k - 1 : k + 1) begin
        exp_q.push_back(row * 4096 + k * 16 + ((k == lk) ? 2 : 0)
                        + ((k == lk && row == lr) ? 1 : 0));
        if (k == lk) break;
      end
      if (row == lr) break;
    end
  endtask

  task automatic run_frame(input int cx, input int ry, input int w, input bit rx,
                           input bit rvy, input int mode, input bit disturb,
                           input string req);
    int cyc;
    int act;
    bit rdy;
    build(cx, ry, w, rx, rvy);
    @(negedge clk);
    cfg_col_start  = 8'(cx);
    cfg_row_start  = 9'(ry);
    cfg_width_kern = 8'(w);
    cfg_rev_x      = rx;
    cfg_rev_y      = rvy;
    frame_start    = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    cyc = 0;
    while (exp_q.size() > 0) begin
      act = out_valid ? (int'(out_row) * 4096 + (int'(out_col) * 2 + int'(out_phase)) * 16
                         + (out_eol ? 2 : 0) + (out_eof ? 1 : 0)) : -1;
      check(act == exp_q[0], (cyc == 0) ? "R2 first beat" : req, act, exp_q[0]);
      rdy = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      out_ready = rdy;
      if (disturb && cyc == 5) begin
        // R2: mid-frame config change and stray start must be ignored
        cfg_col_start  = 8'd0;
        cfg_row_start  = 9'd0;
        cfg_width_kern = 8'd160;
        cfg_rev_x      = ~rx;
        cfg_rev_y      = ~rvy;
        frame_start    = 1'b1;
      end
      cyc++;
      @(negedge clk);
      frame_start = 1'b0;
      if (rdy) void'(exp_q.pop_front());
    end
    out_ready = 1'b1;
    check(!out_valid && !busy, "R9 idle after eof", {out_valid, busy}, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    frame_start = 1'b1;  // R1: start during reset has no effect
    @(negedge clk);
    check(!out_valid && !busy, "R1 in reset", {out_valid, busy}, 0);
    frame_start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!out_valid && !busy, "R1 after reset", {out_valid, busy}, 0);

    run_frame(0, 0, 160, 1'b0, 1'b0, 0, 1'b0, "R11 full frame");
    run_frame(10, 100, 6, 1'b0, 1'b0, 1, 1'b1, "R3 R5 R8 forward throttled");
    run_frame(3, 470, 20, 1'b1, 1'b0, 0, 1'b0, "R4 reverse x clip");
    run_frame(40, 5, 4, 1'b0, 1'b1, 1, 1'b0, "R6 reverse y");
    run_frame(79, 479, 3, 1'b1, 1'b1, 1, 1'b1, "R4 R6 R7 both reversed");
    run_frame(78, 478, 10, 1'b0, 1'b0, 0, 1'b0, "R3 right edge clip");
    run_frame(200, 500, 0, 1'b0, 1'b0, 0, 1'b0, "R10 clamp start and zero width");
    run_frame(0, 479, 255, 1'b0, 1'b0, 1, 1'b0, "R10 oversize width");
    run_frame(5, 2, 1, 1'b1, 1'b1, 0, 1'b0, "R7 single kernel rows");

    repeat (3) @(negedge clk);
    check(!out_valid, "R9 stays idle", out_valid, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule